// File: doc/BRIEF.md
# SIR receive deframer

This block sits between the slow-rate infrared byte receiver and the receive FIFO. Each received byte arrives as a one-cycle valid strobe. The block strips the asynchronous framing from the stream. It discards the fill bytes that precede a frame and the opening and closing delimiters. It drops each escape marker and restores the byte that follows it. Only the frame content goes downstream. The trailing 16-bit check sequence stays attached, because checking it is a later stage's job.

Each frame close produces a one-cycle end strobe with three cause flags:
- a closing delimiter that never came, because a new opening flag arrived first;
- an escape marker cut short by a delimiter;
- a frame longer than the programmed maximum length.

A live byte counter reports how many bytes the current frame has forwarded. Software polls it to tell whether a reception is under way. The two delimiter codes are also presented as one 16-bit constant word.

Top module: `sirx_deframer`

## Requirements
- R1: `delim_pair` always reads 16'hC1C0: opening flag 0xC0 in bits [7:0], closing flag 0xC1 in bits [15:8].
- R2: While no frame is open, every byte other than 0xC0 is dropped with no output strobe and no end strobe. This includes fill bytes 0xFF, 0xC1, 0x7D and data.
- R3: A 0xC0 byte while no frame is open opens a frame, forwards nothing and clears `byte_cnt` to 0 one cycle later.
- R4: Inside an open frame, any byte other than 0xC0, 0xC1 or 0x7D is forwarded unchanged. This includes 0xFF. `out_vld` and `out_byte` appear one cycle after the input strobe, and `byte_cnt` rises by one in the same cycle.
- R5: Inside a frame, an escape byte 0x7D is not forwarded. The next byte is forwarded XORed with 0x20 and counted once.
- R6: A 0xC1 byte in an open frame closes it. `frame_end` pulses for one cycle with all error flags low, provided the length limit was kept. The last two bytes before 0xC1 (the check sequence) are forwarded as ordinary bytes.
- R7: A 0xC0 byte in an open frame closes it. `frame_end` pulses with `err_noeof`, and a new frame opens at the same time with `byte_cnt` cleared to 0.
- R8: A 0x7D byte followed directly by 0xC1 or 0xC0 closes the frame with `frame_end` and `err_esc`, and `err_noeof` stays low. After 0xC1 no frame is open. After 0xC0 a new frame is open with `byte_cnt` 0.
- R9: Once a frame has forwarded `max_len` bytes, further content bytes are not forwarded and `byte_cnt` stays at `max_len`. The frame's close then raises `err_len` with `frame_end`. The flag is cleared for the next frame.
- R10: After a frame closes, `byte_cnt` holds its final value until the next frame opens.
- R11: A cycle with `in_vld` low changes nothing. No strobe appears, `byte_cnt` holds, and a byte value sitting on `in_byte` is not interpreted.
- R12: Reset (active low, asynchronous) clears all strobes and flags, sets `byte_cnt` to 0 and leaves no frame open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| max_len | input | 12 | Largest number of content bytes accepted per frame |
| out_vld | output | 1 | Forwarded byte strobe |
| out_byte | output | 8 | Forwarded (unescaped) byte |
| byte_cnt | output | 12 | Bytes forwarded in the current or last frame |
| frame_end | output | 1 | One-cycle frame close strobe |
| err_noeof | output | 1 | Close caused by an opening flag inside a frame |
| err_esc | output | 1 | Close caused by an escape cut short by a delimiter |
| err_len | output | 1 | Closed frame exceeded `max_len` |
| delim_pair | output | 16 | Constant word holding both delimiter codes |

## Verification
The bench covers several ordering traps.

- A 0xFF inside a frame must pass as data. A design that drops fill bytes everywhere would lose it.
- An escaped byte whose restored value equals a delimiter code (0xE0 becomes 0xC0) must be forwarded and must not close the frame.
- A reopen via 0xC0 must both report the missing close and restart the count. A design that reports without reopening would then swallow the next frame's bytes.
- An escape cut short by 0xC0 versus by 0xC1 must lead to different open states afterwards.

Limit tests cover three cases: a limit of exactly the frame size, a frame one byte over it, and a limit of zero. A design with an off-by-one limit would forward one byte too many or too few, and a design with a sticky overflow flag would taint the following clean frame. A reset in mid-frame and a strobe-free cycle carrying 0xC0 confirm that no frame opens without a valid byte.

// File: rtl/sirx_pkg.sv
package sirx_pkg;

   localparam logic [7:0] SIRX_OPEN_FLAG  = 8'hC0;
   localparam logic [7:0] SIRX_CLOSE_FLAG = 8'hC1;
   localparam logic [7:0] SIRX_ESC_MARK   = 8'h7D;
   localparam logic [7:0] SIRX_FILL_BYTE  = 8'hFF;
   localparam logic [7:0] SIRX_ESC_XOR    = 8'h20;

   typedef enum logic [2:0] {
      CLS_DATA,
      CLS_OPEN,
      CLS_CLOSE,
      CLS_ESC,
      CLS_FILL
   } byte_cls_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BODY,
      ST_ESCAPED
   } rx_state_e;

endpackage

// File: rtl/sirx_classify.sv
module sirx_classify
   import sirx_pkg::*;
#(
   parameter logic [7:0] OPEN_CODE  = SIRX_OPEN_FLAG,
   parameter logic [7:0] CLOSE_CODE = SIRX_CLOSE_FLAG,
   parameter logic [7:0] ESC_CODE   = SIRX_ESC_MARK,
   parameter logic [7:0] FILL_CODE  = SIRX_FILL_BYTE
) (
   input  logic [7:0] byte_in,
   output byte_cls_e  cls
);

   always_comb begin
      if (byte_in == OPEN_CODE)       cls = CLS_OPEN;
      else if (byte_in == CLOSE_CODE) cls = CLS_CLOSE;
      else if (byte_in == ESC_CODE)   cls = CLS_ESC;
      else if (byte_in == FILL_CODE)  cls = CLS_FILL;
      else                            cls = CLS_DATA;
   end

endmodule

// File: rtl/sirx_ctrl.sv
module sirx_ctrl
   import sirx_pkg::*;
#(
   parameter logic [7:0] UNESC_XOR = SIRX_ESC_XOR
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_vld,
   input  byte_cls_e  cls,
   input  logic [7:0] in_byte,
   output logic       fwd_req,
   output logic [7:0] fwd_data,
   output logic       open_evt,
   output logic       close_evt,
   output logic       close_noeof,
   output logic       close_esc
);

   rx_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d     = state_q;
      fwd_req     = 1'b0;
      fwd_data    = in_byte;
      open_evt    = 1'b0;
      close_evt   = 1'b0;
      close_noeof = 1'b0;
      close_esc   = 1'b0;
      if (in_vld) begin
         case (state_q)
            ST_IDLE: begin
               if (cls == CLS_OPEN) begin
                  open_evt = 1'b1;
                  state_d  = ST_BODY;
               end
            end
            ST_BODY: begin
               case (cls)
                  CLS_OPEN: begin
                     close_evt   = 1'b1;
                     close_noeof = 1'b1;
                     open_evt    = 1'b1;
                  end
                  CLS_CLOSE: begin
                     close_evt = 1'b1;
                     state_d   = ST_IDLE;
                  end
                  CLS_ESC: state_d = ST_ESCAPED;
                  default: fwd_req = 1'b1;
               endcase
            end
            ST_ESCAPED: begin
               case (cls)
                  CLS_OPEN: begin
                     close_evt = 1'b1;
                     close_esc = 1'b1;
                     open_evt  = 1'b1;
                     state_d   = ST_BODY;
                  end
                  CLS_CLOSE: begin
                     close_evt = 1'b1;
                     close_esc = 1'b1;
                     state_d   = ST_IDLE;
                  end
                  default: begin
                     fwd_req  = 1'b1;
                     fwd_data = in_byte ^ UNESC_XOR;
                     state_d  = ST_BODY;
                  end
               endcase
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sirx_len_track.sv
module sirx_len_track #(
   parameter int CNT_W      = 12,
   parameter bit DROP_OVER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_evt,
   input  logic             fwd_req,
   input  logic [CNT_W-1:0] max_len,
   output logic             accept,
   output logic             ovf,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic room;
   assign room = (cnt < max_len);

   generate
      if (DROP_OVER) begin : g_drop
         assign accept = fwd_req & room;
      end else begin : g_pass
         assign accept = fwd_req;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (open_evt) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (accept && (cnt != CNT_TOP)) cnt <= cnt + 1'b1;
         if (fwd_req && !room)           ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/sirx_deframer.sv
module sirx_deframer
   import sirx_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter bit DROP_OVER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [7:0]       in_byte,
   input  logic [CNT_W-1:0] max_len,
   output logic             out_vld,
   output logic [7:0]       out_byte,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             frame_end,
   output logic             err_noeof,
   output logic             err_esc,
   output logic             err_len,
   output logic [15:0]      delim_pair
);

   generate
      if (CNT_W < 4 || CNT_W > 16) begin : g_bad_width
         $error("sirx_deframer: CNT_W must lie in 4..16");
      end
   endgenerate

   byte_cls_e  cls;
   logic       fwd_req, open_evt, close_evt, close_noeof, close_esc;
   logic [7:0] fwd_data;
   logic       accept, ovf;

   assign delim_pair = {SIRX_CLOSE_FLAG, SIRX_OPEN_FLAG};

   sirx_classify u_cls (
      .byte_in (in_byte),
      .cls     (cls)
   );

   sirx_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_vld      (in_vld),
      .cls         (cls),
      .in_byte     (in_byte),
      .fwd_req     (fwd_req),
      .fwd_data    (fwd_data),
      .open_evt    (open_evt),
      .close_evt   (close_evt),
      .close_noeof (close_noeof),
      .close_esc   (close_esc)
   );

   sirx_len_track #(.CNT_W(CNT_W), .DROP_OVER(DROP_OVER)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_evt (open_evt),
      .fwd_req  (fwd_req),
      .max_len  (max_len),
      .accept   (accept),
      .ovf      (ovf),
      .cnt      (byte_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         out_byte  <= '0;
         frame_end <= 1'b0;
         err_noeof <= 1'b0;
         err_esc   <= 1'b0;
         err_len   <= 1'b0;
      end else begin
         out_vld   <= accept;
         if (accept) out_byte <= fwd_data;
         frame_end <= close_evt;
         err_noeof <= close_noeof;
         err_esc   <= close_esc;
         err_len   <= close_evt & ovf;
      end
   end

endmodule

// File: rtl/sirx_deframer_chk.sv
module sirx_deframer_chk #(
   parameter int CNT_W     = 12,
   parameter bit DROP_OVER = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic [CNT_W-1:0] max_len,
   input logic             out_vld,
   input logic [CNT_W-1:0] byte_cnt,
   input logic             frame_end,
   input logic             err_noeof,
   input logic             err_esc,
   input logic             err_len
);

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && ($past(byte_cnt) != {CNT_W{1'b1}}))
         |-> (byte_cnt == CNT_W'($past(byte_cnt) + 1'b1)));

   assert_no_vld_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_vld && frame_end));

   assert_err_needs_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_noeof || err_esc || err_len) |-> frame_end);

   assert_single_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_noeof && err_esc));

   assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (!DROP_OVER || ($past(byte_cnt) < $past(max_len))));

   assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_vld && (byte_cnt != '0)) |-> (byte_cnt == $past(byte_cnt)));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && !frame_end));

endmodule

bind sirx_deframer sirx_deframer_chk #(.CNT_W(CNT_W), .DROP_OVER(DROP_OVER)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vld    (in_vld),
   .max_len   (max_len),
   .out_vld   (out_vld),
   .byte_cnt  (byte_cnt),
   .frame_end (frame_end),
   .err_noeof (err_noeof),
   .err_esc   (err_esc),
   .err_len   (err_len)
);

// File: tb/sirx_deframer_tb.sv
module sirx_deframer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic [11:0] max_len = 12'd10;
   logic        out_vld, frame_end, err_noeof, err_esc, err_len;
   logic [7:0]  out_byte;
   logic [11:0] byte_cnt;
   logic [15:0] delim_pair;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sirx_deframer u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
      .max_len(max_len), .out_vld(out_vld), .out_byte(out_byte),
      .byte_cnt(byte_cnt), .frame_end(frame_end), .err_noeof(err_noeof),
      .err_esc(err_esc), .err_len(err_len), .delim_pair(delim_pair)
   );

   // {tag, in, exp_vld, exp_byte, exp_end, exp_errs{len,noeof,esc}, exp_cnt}
   localparam int NV = 26;
   localparam logic [36:0] VEC [NV] = '{
      {4'd2,  8'hFF, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd2,  8'h41, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd2,  8'hC1, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd3,  8'hC0, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd4,  8'h11, 1'b1, 8'h11, 1'b0, 3'b000, 12'd1},
      {4'd4,  8'hFF, 1'b1, 8'hFF, 1'b0, 3'b000, 12'd2},
      {4'd5,  8'h7D, 1'b0, 8'h00, 1'b0, 3'b000, 12'd2},
      {4'd5,  8'h5E, 1'b1, 8'h7E, 1'b0, 3'b000, 12'd3},
      {4'd5,  8'h7D, 1'b0, 8'h00, 1'b0, 3'b000, 12'd3},
      {4'd5,  8'hE0, 1'b1, 8'hC0, 1'b0, 3'b000, 12'd4},
      {4'd6,  8'hAB, 1'b1, 8'hAB, 1'b0, 3'b000, 12'd5},
      {4'd6,  8'hCD, 1'b1, 8'hCD, 1'b0, 3'b000, 12'd6},
      {4'd6,  8'hC1, 1'b0, 8'h00, 1'b1, 3'b000, 12'd6},
      {4'd10, 8'h55, 1'b0, 8'h00, 1'b0, 3'b000, 12'd6},
      {4'd3,  8'hC0, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd4,  8'h22, 1'b1, 8'h22, 1'b0, 3'b000, 12'd1},
      {4'd7,  8'hC0, 1'b0, 8'h00, 1'b1, 3'b010, 12'd0},
      {4'd7,  8'h33, 1'b1, 8'h33, 1'b0, 3'b000, 12'd1},
      {4'd8,  8'h7D, 1'b0, 8'h00, 1'b0, 3'b000, 12'd1},
      {4'd8,  8'hC1, 1'b0, 8'h00, 1'b1, 3'b001, 12'd1},
      {4'd8,  8'h44, 1'b0, 8'h00, 1'b0, 3'b000, 12'd1},
      {4'd3,  8'hC0, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd8,  8'h7D, 1'b0, 8'h00, 1'b0, 3'b000, 12'd0},
      {4'd8,  8'hC0, 1'b0, 8'h00, 1'b1, 3'b001, 12'd0},
      {4'd8,  8'h66, 1'b1, 8'h66, 1'b0, 3'b000, 12'd1},
      {4'd6,  8'hC1, 1'b0, 8'h00, 1'b1, 3'b000, 12'd1}
   };

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd10:   return "R10";
         default: return "R?";
      endcase
   endfunction

   task automatic chk(input string tag, input logic vld, input logic [7:0] b,
                      input logic e, input logic [2:0] errs, input logic [11:0] cnt);
      logic [2:0] got_errs;
      got_errs = {err_len, err_noeof, err_esc};
      n_chk++;
      if (out_vld !== vld || (vld && out_byte !== b) || frame_end !== e ||
          got_errs !== errs || byte_cnt !== cnt) begin
         n_err++;
         $display("FAIL %s: got vld=%b byte=%h end=%b errs=%b cnt=%0d, expected vld=%b byte=%h end=%b errs=%b cnt=%0d",
                  tag, out_vld, out_byte, frame_end, got_errs, byte_cnt,
                  vld, b, e, errs, cnt);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_vld  = 1'b1;
      in_byte = b;
      @(posedge clk);
      #1;
   endtask

   task automatic quiet(input logic [7:0] b);
      @(negedge clk);
      in_vld  = 1'b0;
      in_byte = b;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got running, expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      chk("R12", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      // R1: delimiter word
      n_chk++;
      if (delim_pair !== 16'hC1C0) begin
         n_err++;
         $display("FAIL R1: got %h expected c1c0", delim_pair);
      end
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][32:25]);
         chk(tag_name(VEC[i][36:33]), VEC[i][24], VEC[i][23:16], VEC[i][15],
             VEC[i][14:12], VEC[i][11:0]);
      end

      // R11: strobe-free cycle carrying an opening flag does nothing
      quiet(8'hC0);
      chk("R11", 1'b0, 8'h00, 1'b0, 3'b000, 12'd1);
      send(8'h77);
      chk("R11", 1'b0, 8'h00, 1'b0, 3'b000, 12'd1);

      // R9: limit of 3, frame of 4 content bytes
      max_len = 12'd3;
      send(8'hC0); chk("R9", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      send(8'h01); chk("R9", 1'b1, 8'h01, 1'b0, 3'b000, 12'd1);
      send(8'h02); chk("R9", 1'b1, 8'h02, 1'b0, 3'b000, 12'd2);
      send(8'h03); chk("R9", 1'b1, 8'h03, 1'b0, 3'b000, 12'd3);
      send(8'h04); chk("R9", 1'b0, 8'h00, 1'b0, 3'b000, 12'd3);
      send(8'hC1); chk("R9", 1'b0, 8'h00, 1'b1, 3'b100, 12'd3);
      // R9: exactly at limit is clean, flag cleared
      send(8'hC0); chk("R9", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      send(8'h0A); chk("R9", 1'b1, 8'h0A, 1'b0, 3'b000, 12'd1);
      send(8'h0B); chk("R9", 1'b1, 8'h0B, 1'b0, 3'b000, 12'd2);
      send(8'h0C); chk("R9", 1'b1, 8'h0C, 1'b0, 3'b000, 12'd3);
      send(8'hC1); chk("R9", 1'b0, 8'h00, 1'b1, 3'b000, 12'd3);
      // R9: zero limit
      max_len = 12'd0;
      send(8'hC0); chk("R9", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      send(8'h5A); chk("R9", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      send(8'hC1); chk("R9", 1'b0, 8'h00, 1'b1, 3'b100, 12'd0);

      // R12: reset in mid-frame leaves no frame open
      max_len = 12'd10;
      send(8'hC0);
      send(8'h12); chk("R12", 1'b1, 8'h12, 1'b0, 3'b000, 12'd1);
      @(negedge clk);
      in_vld = 1'b0;
      rst_n  = 1'b0;
      #1;
      chk("R12", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      @(negedge clk);
      rst_n = 1'b1;
      send(8'h34); chk("R12", 1'b0, 8'h00, 1'b0, 3'b000, 12'd0);
      quiet(8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule